// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery loop is frequency locked. It counts edges of the recovered line clock over a fixed gate of reference-clock cycles. It then compares the count against the count a locked loop would produce. It raises a loss-of-lock flag when the error grows past 600 ppm. Once raised, the flag drops only after the error falls under 300 ppm. The gap between the two limits keeps the flag from chattering near a single threshold.

The reference may run at 19.44, 77.76 or 155.52 MHz. The block works out which one is present from the same measurement and reports it as a two-bit code. It then uses the matching line-to-reference ratio for the line rate picked by the rate-select input. The gate count is carried from the recovered-clock domain into the reference domain with a toggle handshake. The flag is updated once per completed gate. A power-down input masks both outputs. When power-down is released, the block starts again as it does after reset.

Top module: `lkd_lock_detect`

## Requirements
- R1: Over every gate of 2^GATE_LOG2 reference cycles, the block counts recovered-clock edges. The expected count is N·2^GATE_LOG2. With rate_sel=0 (622.08 Mb/s line), N is 32, 8 or 4 for a reference of 19.44, 77.76 or 155.52 MHz.
- R2: The reference is classified by checking the gate count against a ±1% window around each candidate N·2^GATE_LOG2. ref_code is 2'b01 for 19.44 MHz, 2'b10 for 77.76 MHz, 2'b11 for 155.52 MHz and 2'b00 for no match.
- R3: A gate count that matches no candidate sets ref_code to 2'b00 and drives lol high.
- R4: While locked (lol low), lol goes high after a gate whose count differs from the expected count by more than ceil(600 ppm of the expected count).
- R5: While out of lock, lol goes low only after a gate whose count differs by less than ceil(300 ppm of the expected count). Errors between the two limits leave lol unchanged in either state.
- R6: Results are applied once per completed gate, a few cycles after the gate ends. The first gate after reset or after power-down release only sets the baseline, so lol stays high until a later full gate meets the 300 ppm criterion.
- R7: While pwr_dn is high, lol and ref_code read 0 from the next cycle onward, whatever the recovered clock does. On release, lol is high and ref_code is 2'b00 until a new lock is found.
- R8: If the handshake started at one gate end has not been answered by the next gate end (recovered clock missing), lol goes high and ref_code becomes 2'b00.
- R9: While rst is high, lol is 1 and ref_code is 2'b00.
- R10: With rate_sel=1 (155.52 Mb/s line), N is 8, 2 or 1 for the three references. The same edge count therefore classifies differently than with rate_sel=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all control logic and outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset (ref_clk domain) |
| rcv_clk | input | 1 | Recovered line clock being measured |
| rate_sel | input | 1 | Line rate: 0 = 622.08 Mb/s, 1 = 155.52 Mb/s |
| pwr_dn | input | 1 | Power-down mask, synchronous to ref_clk |
| lol | output | 1 | Loss-of-lock flag, high when out of lock |
| ref_code | output | 2 | Detected reference: 00 none, 01 19.44, 10 77.76, 11 155.52 MHz |

## Verification
The hardest state to reach is the hysteresis band. A recovered clock 450 ppm off must leave the flag unchanged, and this has to be shown from both the locked side and the unlocked side. The bench generates the recovered clock with femtosecond-resolution half periods computed from a ratio and a ppm offset. It steps 0 → +2000 → +450 ppm and then 0 → +450 ppm, waiting two full gates after each step so that the mixed gate is flushed. A stopped recovered clock, used to provoke the unanswered handshake, and a ratio that matches no reference are produced the same way.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  timeunit 1ns;
  timeprecision 1fs;

  typedef enum logic [1:0] {
    REF_NONE = 2'b00,
    REF_LOW  = 2'b01,
    REF_MID  = 2'b10,
    REF_HIGH = 2'b11
  } ref_code_e;

  // log2 of (line clock / reference) at the fast line rate, per candidate
  function automatic int fast_shift(int idx);
    case (idx)
      0:       return 5;
      1:       return 3;
      default: return 2;
    endcase
  endfunction

  // ceil(base * num / den)
  function automatic longint ceil_frac(longint base, longint num, longint den);
    return (base * num + den - 1) / den;
  endfunction
endpackage

// File: rtl/lkd_sync.sv
module lkd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  timeunit 1ns;
  timeprecision 1fs;

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lkd_rcv_side.sv
// Recovered-clock domain: free-running edge counter, snapshot on request toggle.
module lkd_rcv_side #(
  parameter int CW     = 22,
  parameter int STAGES = 2
) (
  input  logic          rcv_clk,
  input  logic          rst,
  input  logic          req_tgl,
  output logic          ack_tgl,
  output logic [CW-1:0] snap
);
  timeunit 1ns;
  timeprecision 1fs;

  logic          rcv_rst;
  logic          req_s;
  logic          req_seen;
  logic [CW-1:0] edge_cnt;

  lkd_sync #(.STAGES(STAGES)) i_rst_sync (
    .clk(rcv_clk), .rst(1'b0), .d(rst), .q(rcv_rst)
  );

  lkd_sync #(.STAGES(STAGES)) i_req_sync (
    .clk(rcv_clk), .rst(rcv_rst), .d(req_tgl), .q(req_s)
  );

  always_ff @(posedge rcv_clk) begin
    if (rcv_rst) begin
      edge_cnt <= '0;
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      snap     <= '0;
    end else begin
      edge_cnt <= edge_cnt + 1'b1;
      req_seen <= req_s;
      if (req_s != req_seen) begin
        snap    <= edge_cnt;
        ack_tgl <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/lkd_classify.sv
// Matches a gate count to a reference candidate and grades its ppm error.
module lkd_classify
  import lkd_pkg::*;
#(
  parameter int GATE_LOG2 = 14,
  parameter int CW        = GATE_LOG2 + 8
) (
  input  logic [CW-1:0] delta,
  input  logic          rate_sel,
  output logic [1:0]    code,
  output logic          near,
  output logic          far
);
  timeunit 1ns;
  timeprecision 1fs;

  localparam int NCAND = 3;

  logic [NCAND-1:0][CW-1:0] exp_v, win_v, b3_v, b6_v;
  logic [NCAND-1:0]         hit;

  for (genvar i = 0; i < NCAND; i++) begin : g_cand
    localparam int     SH_F  = fast_shift(i);
    localparam longint EXP_F = longint'(1) << (GATE_LOG2 + SH_F);
    localparam longint EXP_S = longint'(1) << (GATE_LOG2 + SH_F - 2);

    assign exp_v[i] = rate_sel ? CW'(EXP_S) : CW'(EXP_F);
    assign win_v[i] = rate_sel ? CW'(ceil_frac(EXP_S, 1, 100))
                               : CW'(ceil_frac(EXP_F, 1, 100));
    assign b3_v[i]  = rate_sel ? CW'(ceil_frac(EXP_S, 300, 1000000))
                               : CW'(ceil_frac(EXP_F, 300, 1000000));
    assign b6_v[i]  = rate_sel ? CW'(ceil_frac(EXP_S, 600, 1000000))
                               : CW'(ceil_frac(EXP_F, 600, 1000000));
    assign hit[i]   = (delta >= exp_v[i] - win_v[i]) && (delta <= exp_v[i] + win_v[i]);
  end

  logic [CW-1:0] sel_exp, sel_b3, sel_b6, diff;

  always_comb begin
    code    = REF_NONE;
    sel_exp = exp_v[0];
    sel_b3  = b3_v[0];
    sel_b6  = b6_v[0];
    for (int k = 0; k < NCAND; k++) begin
      if (hit[k]) begin
        code    = 2'(k + 1);
        sel_exp = exp_v[k];
        sel_b3  = b3_v[k];
        sel_b6  = b6_v[k];
      end
    end
    diff = (delta >= sel_exp) ? delta - sel_exp : sel_exp - delta;
    near = (code != REF_NONE) && (diff < sel_b3);
    far  = diff > sel_b6;
  end
endmodule

// File: rtl/lkd_lock_detect.sv
module lkd_lock_detect
  import lkd_pkg::*;
#(
  parameter int GATE_LOG2   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       rcv_clk,
  input  logic       rate_sel,
  input  logic       pwr_dn,
  output logic       lol,
  output logic [1:0] ref_code
);
  timeunit 1ns;
  timeprecision 1fs;

  localparam int CW = GATE_LOG2 + 8;

  logic [GATE_LOG2-1:0] gate_cnt;
  logic                 gate_end;
  logic                 req_tgl, ack_tgl, ack_s, ack_seen, ack_evt;
  logic                 need_base, lock_bad;
  logic [CW-1:0]        snap, prev_snap, delta;
  logic [1:0]           cls_code;
  logic                 near, far;

  lkd_rcv_side #(.CW(CW), .STAGES(SYNC_STAGES)) i_rcv (
    .rcv_clk(rcv_clk), .rst(rst), .req_tgl(req_tgl), .ack_tgl(ack_tgl), .snap(snap)
  );

  lkd_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk(ref_clk), .rst(rst), .d(ack_tgl), .q(ack_s)
  );

  assign gate_end = &gate_cnt;
  assign ack_evt  = ack_s ^ ack_seen;
  assign delta    = snap - prev_snap;

  lkd_classify #(.GATE_LOG2(GATE_LOG2), .CW(CW)) i_cls (
    .delta(delta), .rate_sel(rate_sel), .code(cls_code), .near(near), .far(far)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      gate_cnt  <= '0;
      req_tgl   <= 1'b0;
      ack_seen  <= 1'b0;
      prev_snap <= '0;
      need_base <= 1'b1;
      lock_bad  <= 1'b1;
      ref_code  <= REF_NONE;
      lol       <= 1'b1;
    end else begin
      ack_seen <= ack_s;
      if (ack_evt) prev_snap <= snap;
      if (pwr_dn) begin
        gate_cnt  <= '0;
        need_base <= 1'b1;
        lock_bad  <= 1'b1;
        ref_code  <= REF_NONE;
        lol       <= 1'b0;
      end else begin
        gate_cnt <= gate_cnt + 1'b1;
        lol      <= lock_bad;
        if (ack_evt) begin
          if (need_base) begin
            need_base <= 1'b0;
          end else begin
            ref_code <= cls_code;
            if (cls_code == REF_NONE) lock_bad <= 1'b1;
            else if (lock_bad)        lock_bad <= ~near;
            else if (far)             lock_bad <= 1'b1;
          end
        end
        if (gate_end) begin
          if (req_tgl != ack_s) begin
            need_base <= 1'b1;
            lock_bad  <= 1'b1;
            ref_code  <= REF_NONE;
          end else begin
            req_tgl <= ~req_tgl;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lkd_lock_detect_chk.sv
module lkd_lock_detect_chk (
  input logic       ref_clk,
  input logic       rst,
  input logic       pwr_dn,
  input logic       lol,
  input logic [1:0] ref_code,
  input logic       req_tgl,
  input logic       ack_s,
  input logic       ack_evt,
  input logic       gate_end,
  input logic       lock_bad,
  input logic       near,
  input logic       far,
  input logic [1:0] cls_code
);
  timeunit 1ns;
  timeprecision 1fs;

  p_pdn_mask_r7: assert property (@(posedge ref_clk) disable iff (rst)
    pwr_dn |=> (!lol && ref_code == 2'b00));

  p_none_lol_r3: assert property (@(posedge ref_clk) disable iff (rst)
    (ref_code == 2'b00 && !pwr_dn) |=> (lol || pwr_dn));

  p_relock_r5: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(lock_bad) |-> $past(near && ack_evt));

  p_lose_r4: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(lock_bad) |-> $past(pwr_dn || gate_end || (ack_evt && (far || cls_code == 2'b00))));

  p_gate_step_r6: assert property (@(posedge ref_clk) disable iff (rst)
    !$stable(lol) |-> ($past(rst) || $past(pwr_dn) || $past(pwr_dn, 2) ||
                       $past(ack_evt, 2) || $past(gate_end, 2)));

  p_req_idle_r8: assert property (@(posedge ref_clk) disable iff (rst)
    !$stable(req_tgl) |-> $past(gate_end && req_tgl == ack_s));
endmodule

bind lkd_lock_detect lkd_lock_detect_chk i_chk (
  .ref_clk(ref_clk), .rst(rst), .pwr_dn(pwr_dn), .lol(lol), .ref_code(ref_code),
  .req_tgl(req_tgl), .ack_s(ack_s), .ack_evt(ack_evt), .gate_end(gate_end),
  .lock_bad(lock_bad), .near(near), .far(far), .cls_code(cls_code)
);

// File: tb/test_lkd_lock_detect.sv
module test_lkd_lock_detect;
  timeunit 1ns;
  timeprecision 1fs;

  localparam int GL   = 12;
  localparam int GATE = 1 << GL;
  localparam int WF   = 2 * GATE + 64;

  logic       ref_clk  = 1'b0;
  logic       rst      = 1'b1;
  logic       rcv_clk  = 1'b0;
  logic       rate_sel = 1'b0;
  logic       pwr_dn   = 1'b0;
  logic       lol;
  logic [1:0] ref_code;

  real rcv_half = 0.25;
  bit  rcv_on   = 1'b1;
  bit  done     = 1'b0;
  int  checks   = 0;
  int  errors   = 0;
  int  cyc      = 0;

  typedef struct {
    logic       lol;
    logic [1:0] code;
    string      tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;

  lkd_lock_detect #(.GATE_LOG2(GL)) i_lkd_lock_detect (
    .ref_clk(ref_clk), .rst(rst), .rcv_clk(rcv_clk), .rate_sel(rate_sel),
    .pwr_dn(pwr_dn), .lol(lol), .ref_code(ref_code)
  );

  always #2 ref_clk = ~ref_clk;

  initial forever begin
    if (rcv_on) begin
      #(rcv_half);
      rcv_clk = ~rcv_clk;
    end else begin
      #1;
    end
  end

  // recovered clock = n x reference, offset by ppm
  task automatic set_rcv(input int n, input real ppm);
    rcv_half = 2.0 / (real'(n) * (1.0 + ppm * 1.0e-6));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic expect_state(input logic l, input logic [1:0] c, input string tag);
    sb.push_back('{l, c, tag});
    wait (sb.size() == 0);
    @(negedge ref_clk);
  endtask

  // monitor / scoreboard
  initial forever begin
    wait (sb.size() != 0);
    @(negedge ref_clk);
    cur = sb.pop_front();
    checks++;
    if (lol !== cur.lol || ref_code !== cur.code) begin
      errors++;
      $display("FAIL %s: lol=%0b ref_code=%02b, expected lol=%0b ref_code=%02b",
               cur.tag, lol, ref_code, cur.lol, cur.code);
    end
  end

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 180000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_rcv(8, 0.0);
    idle(20);
    expect_state(1'b1, 2'b00, "R9 reset state");
    rst = 1'b0;
    idle(GATE + GATE / 2);
    expect_state(1'b1, 2'b00, "R6 first gate only sets baseline");
    idle(GATE / 2 + 64);
    expect_state(1'b0, 2'b10, "R1/R2 77.76 MHz at fast rate locks");

    set_rcv(8, 2000.0);
    idle(WF);
    expect_state(1'b1, 2'b10, "R4 +2000 ppm loses lock");
    set_rcv(8, 450.0);
    idle(WF);
    expect_state(1'b1, 2'b10, "R5 450 ppm keeps lost state");
    set_rcv(8, 0.0);
    idle(WF);
    expect_state(1'b0, 2'b10, "R5 0 ppm relocks");
    set_rcv(8, 450.0);
    idle(WF);
    expect_state(1'b0, 2'b10, "R4 450 ppm keeps lock");
    set_rcv(8, -2000.0);
    idle(WF);
    expect_state(1'b1, 2'b10, "R4 -2000 ppm loses lock");

    pwr_dn = 1'b1;
    idle(3);
    expect_state(1'b0, 2'b00, "R7 power-down masks outputs");
    idle(GATE);
    expect_state(1'b0, 2'b00, "R7 off-frequency ignored in power-down");
    set_rcv(8, 0.0);
    pwr_dn = 1'b0;
    idle(GATE + GATE / 2);
    expect_state(1'b1, 2'b00, "R7/R6 held after release");
    idle(GATE / 2 + 64);
    expect_state(1'b0, 2'b10, "R6 relock after release");

    rate_sel = 1'b1;
    idle(WF);
    expect_state(1'b0, 2'b01, "R10 ratio 8 at slow rate is 19.44 MHz");
    set_rcv(2, 0.0);
    idle(WF);
    expect_state(1'b0, 2'b10, "R10 ratio 2 at slow rate is 77.76 MHz");
    set_rcv(1, 0.0);
    idle(WF);
    expect_state(1'b0, 2'b11, "R10 ratio 1 at slow rate is 155.52 MHz");

    rate_sel = 1'b0;
    set_rcv(32, 0.0);
    idle(WF);
    expect_state(1'b0, 2'b01, "R1 ratio 32 at fast rate is 19.44 MHz");
    set_rcv(4, 0.0);
    idle(WF);
    expect_state(1'b0, 2'b11, "R1 ratio 4 at fast rate is 155.52 MHz");
    set_rcv(5, 0.0);
    idle(WF);
    expect_state(1'b1, 2'b00, "R3 unmatched ratio");
    set_rcv(8, 5000.0);
    idle(WF);
    expect_state(1'b1, 2'b10, "R2 0.5 percent inside class window but unlocked");

    rcv_on = 1'b0;
    idle(WF);
    expect_state(1'b1, 2'b00, "R8 recovered clock missing");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule